// File: doc/BRIEF.md
# Tuple History Table Compressor

This block is a second-level compressor for a trace of small cache indices. It collects the incoming indices into groups of a fixed size (tuples). When a tuple is complete, it is compared at once against a short history of tuples recently sent in full. If one of them matches, only the position of that entry goes out on the hit trace.

If nothing matches, the hit trace carries the reserved code zero and the complete tuple goes out on the miss trace. The new tuple is then inserted at the newest end of the history, and the oldest entry is dropped.

The tuple size, the history depth and the index width are parameters. Packing the two traces into bytes and driving an output port happen downstream of this block.

Top module: `tuple_hist_compressor`

## Requirements
- R1: While reset is high and in the first cycle after it, `hit_valid` and `miss_valid` are 0. All history entries start out invalid, so no tuple can hit before it has first missed. This holds even for a tuple whose indices are all zero.
- R2: A lookup happens only in a cycle in which `in_valid` delivers the TUPLE_N-th index of a group. `hit_valid` is 1 in exactly the cycle after that one and is 0 in every other cycle. A partial group produces no output.
- R3: On a miss, `hit_code` is 0, `miss_valid` is 1 and `miss_tuple` holds the tuple. The first index received sits in bits [IDX_W-1:0], and index k sits in bits [k*IDX_W +: IDX_W].
- R4: On a hit, `hit_code` is the position of the matching entry, in the range 1 to HIST_DEPTH-1, and `miss_valid` is 0.
- R5: Position 1 holds the most recently inserted tuple. A miss inserts the tuple at position 1 and moves every other entry one position up. When all HIST_DEPTH-1 positions are full, the entry that was at position HIST_DEPTH-1 is lost.
- R6: A hit leaves the history unchanged. Every entry keeps its position.
- R7: Cycles with `in_valid` low between indices do not disturb the group being collected.
- R8: The group buffer empties after each lookup. The next index received becomes element 0 of a new tuple, so groups never overlap.
- R9: A tuple completed in the cycle right after a miss is compared against the history that already contains the tuple from that miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An index is present on `in_index` this cycle |
| in_index | input | IDX_W | Incoming cache index |
| hit_valid | output | 1 | A lookup result is present (hit trace entry) |
| hit_code | output | $clog2(HIST_DEPTH) | Position of the matching entry, or 0 for a miss |
| miss_valid | output | 1 | A miss-trace entry is present |
| miss_tuple | output | IDX_W*TUPLE_N | Complete tuple sent on a miss |

## Verification
The hardest situations to reach from the ports are three:
- an eviction from a full history, followed by a lookup of the evicted tuple;
- a lookup of the all-zero tuple while entries are still invalid;
- a tuple completed back-to-back with the miss that has just changed the table.

A small configuration (2-bit indices, pairs, three positions) makes every one of the sixteen tuples reachable. A directed sequence forces each of these situations. A long arithmetic sweep then mixes a few recurring tuples with scattered ones and varies the idle gaps, so that hits at every position, evictions and consecutive lookups all occur many times against a bench-side model of the history.

// File: rtl/thc_pkg.sv
package thc_pkg;

    // Outcome of one tuple lookup, carried in the output register
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HIT  = 2'd1,
        LK_MISS = 2'd2
    } lookup_kind_e;

    // Width of a counter that must hold values 0 .. n-1 (at least 1 bit)
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

    // Slice offset of element k inside a packed tuple
    function automatic int unsigned elem_lsb(input int unsigned k, input int unsigned w);
        return k * w;
    endfunction

endpackage

// File: rtl/thc_gather.sv
module thc_gather
    import thc_pkg::*;
#(
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned TUPLE_N = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [IDX_W-1:0]           in_index,
    output logic                       tuple_done,
    output logic [IDX_W*TUPLE_N-1:0]   tuple_word
);
    localparam int unsigned CNT_W = cnt_width(TUPLE_N);
    localparam int unsigned LAST  = TUPLE_N - 1;

    logic [CNT_W-1:0] fill_q;
    logic [IDX_W-1:0] slot_q [LAST];

    assign tuple_done = in_valid && (fill_q == CNT_W'(LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (in_valid) begin
            fill_q <= tuple_done ? '0 : fill_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < int'(LAST); k++) begin
            if (in_valid && (fill_q == CNT_W'(k))) begin
                slot_q[k] <= in_index;
            end
        end
    end

    // Earlier elements come from the buffer, the last one straight from the input
    for (genvar k = 0; k < int'(TUPLE_N); k++) begin : g_elem
        if (k < int'(LAST)) begin : g_buf
            assign tuple_word[elem_lsb(k, IDX_W) +: IDX_W] = slot_q[k];
        end else begin : g_live
            assign tuple_word[elem_lsb(k, IDX_W) +: IDX_W] = in_index;
        end
    end

endmodule

// File: rtl/thc_history.sv
module thc_history #(
    parameter int unsigned TUP_W   = 24,
    parameter int unsigned ENTRIES = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TUP_W-1:0]   key,
    input  logic               push,
    output logic [ENTRIES-1:0] match_vec
);
    logic [TUP_W-1:0]   ent_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;

    // One comparator per entry, all evaluated in the same cycle
    for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_cmp
        assign match_vec[e] = vld_q[e] && (ent_q[e] == key);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (push) begin
            vld_q <= {vld_q[ENTRIES-2:0], 1'b1};
        end
    end

    // Shift toward older positions; index 0 is position 1 (newest)
    always_ff @(posedge clk) begin
        if (push) begin
            ent_q[0] <= key;
            for (int e = 1; e < int'(ENTRIES); e++) begin
                ent_q[e] <= ent_q[e-1];
            end
        end
    end

endmodule

// File: rtl/thc_encode.sv
module thc_encode #(
    parameter int unsigned ENTRIES = 15,
    parameter int unsigned CODE_W  = 4
) (
    input  logic [ENTRIES-1:0] match_vec,
    output logic               any_hit,
    output logic [CODE_W-1:0]  code
);
    // Lowest matching position wins; scanning downward leaves it last
    always_comb begin
        code = '0;
        for (int e = int'(ENTRIES) - 1; e >= 0; e--) begin
            if (match_vec[e]) begin
                code = CODE_W'(e + 1);
            end
        end
    end

    assign any_hit = |match_vec;

endmodule

// File: rtl/tuple_hist_compressor.sv
module tuple_hist_compressor
    import thc_pkg::*;
#(
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned TUPLE_N    = 4,
    parameter int unsigned HIST_DEPTH = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic [IDX_W-1:0]                  in_index,
    output logic                              hit_valid,
    output logic [$clog2(HIST_DEPTH)-1:0]     hit_code,
    output logic                              miss_valid,
    output logic [IDX_W*TUPLE_N-1:0]          miss_tuple
);
    localparam int unsigned TUP_W   = IDX_W * TUPLE_N;
    localparam int unsigned ENTRIES = HIST_DEPTH - 1;
    localparam int unsigned CODE_W  = $clog2(HIST_DEPTH);

    initial begin
        if (TUPLE_N < 2 || HIST_DEPTH < 3) begin
            $error("tuple_hist_compressor: TUPLE_N must be >= 2 and HIST_DEPTH >= 3");
        end
    end

    logic               tuple_done;
    logic [TUP_W-1:0]   tuple_word;
    logic [ENTRIES-1:0] match_vec;
    logic               any_hit;
    logic [CODE_W-1:0]  pos_code;
    logic               push;

    lookup_kind_e       kind_q;
    logic [CODE_W-1:0]  code_q;
    logic [TUP_W-1:0]   tuple_q;

    thc_gather #(
        .IDX_W   (IDX_W),
        .TUPLE_N (TUPLE_N)
    ) u_gather (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_index   (in_index),
        .tuple_done (tuple_done),
        .tuple_word (tuple_word)
    );

    assign push = tuple_done && !any_hit;

    thc_history #(
        .TUP_W   (TUP_W),
        .ENTRIES (ENTRIES)
    ) u_history (
        .clk       (clk),
        .rst       (rst),
        .key       (tuple_word),
        .push      (push),
        .match_vec (match_vec)
    );

    thc_encode #(
        .ENTRIES (ENTRIES),
        .CODE_W  (CODE_W)
    ) u_encode (
        .match_vec (match_vec),
        .any_hit   (any_hit),
        .code      (pos_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= LK_IDLE;
            code_q <= '0;
        end else if (tuple_done) begin
            kind_q <= any_hit ? LK_HIT : LK_MISS;
            code_q <= any_hit ? pos_code : '0;
        end else begin
            kind_q <= LK_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            tuple_q <= tuple_word;
        end
    end

    assign hit_valid  = (kind_q != LK_IDLE);
    assign miss_valid = (kind_q == LK_MISS);
    assign hit_code   = code_q;
    assign miss_tuple = tuple_q;

endmodule

// File: rtl/tuple_hist_compressor_chk.sv
module tuple_hist_compressor_chk #(
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned TUPLE_N    = 4,
    parameter int unsigned HIST_DEPTH = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic [IDX_W-1:0]              in_index,
    input logic                          hit_valid,
    input logic [$clog2(HIST_DEPTH)-1:0] hit_code,
    input logic                          miss_valid,
    input logic [IDX_W*TUPLE_N-1:0]      miss_tuple
);
    int unsigned seen_cnt;

    // Independent count of indices modulo the group size
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_cnt <= 0;
        end else if (in_valid) begin
            seen_cnt <= (seen_cnt == TUPLE_N - 1) ? 0 : seen_cnt + 1;
        end
    end

    // R1: no output in the first cycle after reset is released
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!hit_valid && !miss_valid));

    // R2: completing a group produces a result in the next cycle
    a_r2_lookup_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seen_cnt == TUPLE_N - 1) |=> hit_valid);

    // R2: a result appears only after a completing index
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> ($past(in_valid) && $past(seen_cnt) == TUPLE_N - 1));

    // R3: a miss-trace entry always pairs with code zero on the hit trace
    a_r3_miss_code_zero: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> (hit_valid && hit_code == 0));

    // R4: a nonzero code is a valid position and carries no miss entry
    a_r4_hit_position: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && hit_code != 0) |-> (!miss_valid && hit_code <= HIST_DEPTH - 1));

    // Tie-off of the unused observation inputs
    logic unused_ok;
    assign unused_ok = ^{in_index, miss_tuple};

endmodule

bind tuple_hist_compressor tuple_hist_compressor_chk #(
    .IDX_W      (IDX_W),
    .TUPLE_N    (TUPLE_N),
    .HIST_DEPTH (HIST_DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_index   (in_index),
    .hit_valid  (hit_valid),
    .hit_code   (hit_code),
    .miss_valid (miss_valid),
    .miss_tuple (miss_tuple)
);

// File: tb/test_tuple_hist_compressor.sv
`timescale 1ns/1ps
module test_tuple_hist_compressor;
    localparam int IW = 2;
    localparam int TN = 2;
    localparam int HD = 4;
    localparam int NE = HD - 1;
    localparam int CW = $clog2(HD);
    localparam int TW = IW * TN;

    logic          clk = 0;
    logic          rst = 1;
    logic          in_valid = 0;
    logic [IW-1:0] in_index = '0;
    logic          hit_valid;
    logic [CW-1:0] hit_code;
    logic          miss_valid;
    logic [TW-1:0] miss_tuple;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    tuple_hist_compressor #(.IDX_W(IW), .TUPLE_N(TN), .HIST_DEPTH(HD)) i_tuple_hist_compressor (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_index(in_index),
        .hit_valid(hit_valid), .hit_code(hit_code),
        .miss_valid(miss_valid), .miss_tuple(miss_tuple)
    );

    // Bench-side history: index 0 is position 1 (newest)
    logic [TW-1:0] m_ent [NE];
    bit            m_vld [NE];

    // Expectation attached to the driven completing index
    bit            drv_last = 0;
    int            drv_code = 0;
    logic [TW-1:0] drv_tuple = '0;
    string         drv_tag = "";

    bit            exp_q = 0;
    int            exp_code_q = 0;
    logic [TW-1:0] exp_tuple_q = '0;
    string         exp_tag_q = "";

    function automatic int model_lookup(input logic [TW-1:0] t);
        for (int e = 0; e < NE; e++) begin
            if (m_vld[e] && m_ent[e] == t) return e + 1;
        end
        for (int e = NE - 1; e > 0; e--) begin
            m_ent[e] = m_ent[e-1];
            m_vld[e] = m_vld[e-1];
        end
        m_ent[0] = t;
        m_vld[0] = 1;
        return 0;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
            drv_last = 0;
        end
    endtask

    // First index a goes to bits [1:0], second index b to bits [3:2] (R3)
    task automatic send_tuple(input int a, input int b, input int gap, input string tag);
        logic [TW-1:0] t;
        t = {IW'(b), IW'(a)};
        @(negedge clk);
        in_valid = 1;
        in_index = IW'(a);
        drv_last = 0;
        idle(gap);
        @(negedge clk);
        in_valid  = 1;
        in_index  = IW'(b);
        drv_last  = 1;
        drv_code  = model_lookup(t);
        drv_tuple = t;
        drv_tag   = tag;
    endtask

    always @(posedge clk) begin
        exp_q       <= in_valid && drv_last && !rst;
        exp_code_q  <= drv_code;
        exp_tuple_q <= drv_tuple;
        exp_tag_q   <= drv_tag;
    end

    always @(negedge clk) begin
        if (!rst && !done && (exp_q || hit_valid)) begin
            bit ok;
            ok = (hit_valid == exp_q);
            if (ok && exp_q) begin
                ok = (int'(hit_code) == exp_code_q) && (miss_valid == (exp_code_q == 0));
                if (exp_code_q == 0) ok = ok && (miss_tuple == exp_tuple_q);
            end
            checks++;
            if (!ok) begin
                errors++;
                $display("FAIL %s: hit_valid=%0d code=%0d miss_valid=%0d tuple=%h expected hit_valid=%0d code=%0d miss_valid=%0d tuple=%h",
                         exp_q ? exp_tag_q : "R2", hit_valid, hit_code, miss_valid, miss_tuple,
                         exp_q, exp_code_q, exp_code_q == 0, exp_tuple_q);
            end
        end
    end

    task automatic check_quiet(input string tag);
        checks++;
        if (hit_valid !== 1'b0 || miss_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: hit_valid=%0d miss_valid=%0d expected 0 0", tag, hit_valid, miss_valid);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int e = 0; e < NE; e++) begin m_ent[e] = '0; m_vld[e] = 0; end
        repeat (3) @(negedge clk);
        check_quiet("R1 during reset");
        rst = 0;
        @(negedge clk);
        check_quiet("R1 after reset");

        // R1: all-zero tuple must miss against invalid entries
        send_tuple(0, 0, 0, "R1 zero tuple misses");
        send_tuple(0, 0, 0, "R9 back-to-back hit at position 1");
        send_tuple(1, 2, 1, "R3 miss with gap R7");
        send_tuple(0, 0, 0, "R5 older entry at position 2");
        send_tuple(0, 0, 2, "R6 hit keeps table");
        send_tuple(3, 3, 0, "R5 fill to full");
        send_tuple(0, 0, 0, "R5 entry now at position 3");
        send_tuple(2, 1, 0, "R5 insert evicts oldest");
        send_tuple(0, 0, 0, "R5 evicted tuple misses");
        idle(2);

        // R2 and R7: a partial group produces nothing while idle
        @(negedge clk);
        in_valid = 1; in_index = 2'd3; drv_last = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 0;
            check_quiet("R2 partial group silent");
        end
        // Completing that group directly: element 0 is the 3 from before
        @(negedge clk);
        in_valid = 1; in_index = 2'd1; drv_last = 1;
        drv_code = model_lookup({2'd1, 2'd3}); drv_tuple = {2'd1, 2'd3};
        drv_tag = "R7 group spans idle cycles";
        // R8: next group starts fresh
        send_tuple(2, 0, 0, "R8 no overlap between groups");
        idle(2);

        // Sweep: recurring tuples mixed with scattered ones, varied gaps
        for (int k = 0; k < 400; k++) begin
            int t;
            int g;
            t = (k % 4 < 2) ? ((k / 4) % 4) * 5 % 16 : (k * k * 3 + k * 7) % 16;
            g = (k % 7 == 0) ? 2 : ((k % 3 == 0) ? 1 : 0);
            send_tuple(t % 4, t / 4, g, (k % 2 == 0) ? "R4 sweep" : "R3 sweep");
        end
        idle(4);
        finish_run();
    end
endmodule